// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block is a read-only data port that can be viewed either as a 16-bit-wide word store or as a byte store with twice as many locations. The contents are not loaded from anywhere. They are computed by a parameterised arithmetic function of the word index. A mode input chooses the view. In byte view, a dedicated input acts as the least significant byte-address bit. That input stands for the pin that carries data bit 15 in word view. A selector places the chosen half of the addressed word on the low lane, and the high lane stays dark.

Output gating uses three controls:
- An active-low chip enable.
- An active-low output enable.
- A second output enable. A build-time parameter chooses whether it is active high, active low or ignored.

There is no tristate. Each lane has its own output-enable vector, and the data on a disabled lane reads zero. A standby flag reports when the chip enable is inactive.

All inputs are registered on each rising clock edge. The outputs are decoded from those registers, so the result for a set of inputs appears one cycle after the edge that samples them.

The registered control forms a five-state machine:
- `ST_STANDBY`: chip enable inactive.
- `ST_MUTED`: chip selected, but an output enable is inactive.
- `ST_WORD`: word view, both lanes driven.
- `ST_BYTE_LO`: byte view with the byte-select bit low.
- `ST_BYTE_HI`: byte view with the byte-select bit high.

Every edge is a transition. From any state, the next state is chosen by priority:
1. Chip enable inactive gives `ST_STANDBY`.
2. Otherwise, a failed enable gives `ST_MUTED`.
3. Otherwise, word view gives `ST_WORD`.
4. Otherwise, the byte-select bit picks `ST_BYTE_HI` (bit high) or `ST_BYTE_LO` (bit low).

Reset enters `ST_STANDBY`.

Top module: `dual_width_rom_port`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, the second enable active and `word_mode`=1, one cycle later `dout` equals the word at index `addr`, and `oe_lo` and `oe_hi` are all ones. The word at index a is bits [DATA_W-1:0] of (a*CMUL) XOR CSEED, computed in 32 bits.
- R2: Under the same enables with `word_mode`=0 and `lsb_in`=0, one cycle later `dout[7:0]` carries bits [7:0] of the word at `addr`, and `oe_lo` is all ones.
- R3: With `word_mode`=0 and `lsb_in`=1, one cycle later `dout[7:0]` carries bits [15:8] of the word at `addr`. In byte view with any enables, `oe_hi` is all zeros and `dout[15:8]` is zero.
- R4: `ce_n`=1 makes `standby`=1, both enable vectors zero and `dout` zero one cycle later, whatever the other inputs are. With `ce_n`=0, `standby` is 0.
- R5: `ce_n`=0 with `oe_n`=1 gives both enable vectors zero, `dout` zero and `standby`=0 one cycle later.
- R6: The second enable `oe2` follows `OE2_MODE`. Value 0 (active high) mutes the outputs like R5 when `oe2`=0. Value 1 (active low) mutes them when `oe2`=1. Value 2 (ignore) never mutes them.
- R7: In word view `lsb_in` has no effect on any output.
- R8: Any lane whose enable vector is zero reads zero on `dout`.
- R9: During reset, `standby`=1 and `dout`, `oe_lo` and `oe_hi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Main output enable, active low |
| oe2 | input | 1 | Second output enable, polarity set by OE2_MODE |
| word_mode | input | 1 | 1 = word view, 0 = byte view |
| lsb_in | input | 1 | Byte-select address bit in byte view; ignored in word view |
| addr | input | ADDR_W | Word index |
| dout | output | DATA_W | Read data; zero on disabled lanes |
| oe_lo | output | DATA_W/2 | Per-bit enable of the low lane |
| oe_hi | output | DATA_W/2 | Per-bit enable of the high lane |
| standby | output | 1 | High while chip enable is inactive |

## Verification
The risky coincidence is a view switch that lands in the same cycle as a change of `lsb_in`. On that edge the pin's role flips between address bit and ignored data bit. The bench provokes it by moving `word_mode` and `lsb_in` together in both directions, across several addresses. It judges the output of the following cycle: word data with both lanes on after a switch into word view, and the selected half with the high lane dark after a switch into byte view. A second overlap, between the enable gating and a view change, is driven by dropping `oe_n` or `ce_n` in the same cycle as the mode flip. In that case the bench expects the muted or standby pattern to win.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_MUTED,
        ST_WORD,
        ST_BYTE_LO,
        ST_BYTE_HI
    } port_state_e;

    typedef enum logic [1:0] {
        OE2_ACT_HIGH = 2'd0,
        OE2_ACT_LOW  = 2'd1,
        OE2_IGNORE   = 2'd2
    } oe2_mode_e;

    // Contents generator: product of index and multiplier, xored with a seed.
    function automatic logic [31:0] rom_word_value(input logic [31:0] idx,
                                                   input logic [31:0] mul,
                                                   input logic [31:0] seed);
        return (idx * mul) ^ seed;
    endfunction

endpackage

// File: rtl/rom_port_fsm.sv
module rom_port_fsm
    import rom_port_pkg::*;
#(
    parameter int        ADDR_W   = 17,
    parameter oe2_mode_e OE2_MODE = OE2_ACT_HIGH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              oe2,
    input  logic              word_mode,
    input  logic              lsb_in,
    input  logic [ADDR_W-1:0] addr,
    output port_state_e       state,
    output logic [ADDR_W-1:0] word_addr
);

    localparam logic OE2_INV = (OE2_MODE == OE2_ACT_LOW);
    localparam logic OE2_DC  = (OE2_MODE == OE2_IGNORE);

    logic        oe2_ok;
    logic        en_ok;
    port_state_e state_nx;

    // Second enable: flipped for active-low builds, forced on when ignored.
    assign oe2_ok = (oe2 ^ OE2_INV) | OE2_DC;
    assign en_ok  = ~oe_n & oe2_ok;

    always_comb begin
        unique casez ({ce_n, en_ok, word_mode, lsb_in})
            4'b1???: state_nx = ST_STANDBY;
            4'b00??: state_nx = ST_MUTED;
            4'b011?: state_nx = ST_WORD;
            4'b0100: state_nx = ST_BYTE_LO;
            4'b0101: state_nx = ST_BYTE_HI;
            default: state_nx = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_STANDBY;
            word_addr <= '0;
        end else begin
            state     <= state_nx;
            word_addr <= addr;
        end
    end

    AST_CE_FORCES_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> (state == ST_STANDBY)); // R4

    AST_WORD_NOT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_mode)) |->
        (state != ST_BYTE_LO && state != ST_BYTE_HI)); // R7

endmodule

// File: rtl/rom_content.sv
module rom_content
    import rom_port_pkg::*;
#(
    parameter int          ADDR_W = 17,
    parameter int          DATA_W = 16,
    parameter logic [31:0] CMUL   = 32'h0000_9E37,
    parameter logic [31:0] CSEED  = 32'h0000_5AC3
) (
    input  logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] word
);

    logic [31:0] idx32;
    logic [31:0] full;

    always_comb begin
        idx32 = 32'(word_addr);
        full  = rom_word_value(idx32, CMUL, CSEED);
        word  = full[DATA_W-1:0];
    end

endmodule

// File: rtl/rom_lane_steer.sv
module rom_lane_steer
    import rom_port_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANE_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_state_e       state,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] dout,
    output logic [LANE_W-1:0] oe_lo,
    output logic [LANE_W-1:0] oe_hi,
    output logic              standby
);

    always_comb begin
        dout    = '0;
        oe_lo   = '0;
        oe_hi   = '0;
        standby = 1'b0;
        unique case (state)
            ST_STANDBY: standby = 1'b1;
            ST_MUTED:   standby = 1'b0;
            ST_WORD: begin
                dout  = word;
                oe_lo = '1;
                oe_hi = '1;
            end
            ST_BYTE_LO: begin
                dout  = {{LANE_W{1'b0}}, word[LANE_W-1:0]};
                oe_lo = '1;
            end
            ST_BYTE_HI: begin
                dout  = {{LANE_W{1'b0}}, word[DATA_W-1:LANE_W]};
                oe_lo = '1;
            end
            default: standby = 1'b1;
        endcase
    end

    AST_DARK_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_lo == '0) |-> (dout == '0)); // R8

    AST_HIGH_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hi != '0) |-> (oe_lo == '1)); // R1

endmodule

// File: rtl/dual_width_rom_port.sv
module dual_width_rom_port
    import rom_port_pkg::*;
#(
    parameter int          ADDR_W   = 17,
    parameter int          DATA_W   = 16,
    parameter oe2_mode_e   OE2_MODE = OE2_ACT_HIGH,
    parameter logic [31:0] CMUL     = 32'h0000_9E37,
    parameter logic [31:0] CSEED    = 32'h0000_5AC3,
    localparam int         LANE_W   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              oe2,
    input  logic              word_mode,
    input  logic              lsb_in,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic [LANE_W-1:0] oe_lo,
    output logic [LANE_W-1:0] oe_hi,
    output logic              standby
);

    port_state_e       state;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] word;

    rom_port_fsm #(
        .ADDR_W  (ADDR_W),
        .OE2_MODE(OE2_MODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .oe2      (oe2),
        .word_mode(word_mode),
        .lsb_in   (lsb_in),
        .addr     (addr),
        .state    (state),
        .word_addr(word_addr)
    );

    rom_content #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CMUL  (CMUL),
        .CSEED (CSEED)
    ) u_content (
        .word_addr(word_addr),
        .word     (word)
    );

    rom_lane_steer #(
        .DATA_W(DATA_W)
    ) u_steer (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .word   (word),
        .dout   (dout),
        .oe_lo  (oe_lo),
        .oe_hi  (oe_hi),
        .standby(standby)
    );

    AST_BYTE_HIGH_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(word_mode) |-> (oe_hi == '0 && dout[DATA_W-1:LANE_W] == '0)); // R3

    AST_MUTE_NOT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n) && $past(oe_n)) |->
        (!standby && oe_lo == '0 && oe_hi == '0)); // R5

    AST_STANDBY_TRACKS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (standby == $past(ce_n))); // R4

endmodule

// File: tb/dual_width_rom_port_bench.sv
`timescale 1ns/1ps
module dual_width_rom_port_bench;
    import rom_port_pkg::*;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LW = DW / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, oe2 = 1'b0, word_mode = 1'b0, lsb_in = 1'b0;
    logic [AW-1:0] addr = '0;

    logic [DW-1:0] d_h, d_l, d_i;
    logic [LW-1:0] ol_h, oh_h, ol_l, oh_l, ol_i, oh_i;
    logic sb_h, sb_l, sb_i;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_width_rom_port #(.ADDR_W(AW), .DATA_W(DW), .OE2_MODE(OE2_ACT_HIGH)) u_dual_width_rom_port (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .oe2(oe2),
        .word_mode(word_mode), .lsb_in(lsb_in), .addr(addr),
        .dout(d_h), .oe_lo(ol_h), .oe_hi(oh_h), .standby(sb_h));

    dual_width_rom_port #(.ADDR_W(AW), .DATA_W(DW), .OE2_MODE(OE2_ACT_LOW)) u_dual_width_rom_port_lo (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .oe2(oe2),
        .word_mode(word_mode), .lsb_in(lsb_in), .addr(addr),
        .dout(d_l), .oe_lo(ol_l), .oe_hi(oh_l), .standby(sb_l));

    dual_width_rom_port #(.ADDR_W(AW), .DATA_W(DW), .OE2_MODE(OE2_IGNORE)) u_dual_width_rom_port_dc (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .oe2(oe2),
        .word_mode(word_mode), .lsb_in(lsb_in), .addr(addr),
        .dout(d_i), .oe_lo(ol_i), .oe_hi(oh_i), .standby(sb_i));

    function automatic logic [15:0] ref_word(input int a);
        int unsigned p;
        p = (a * 40503) ^ 23235;
        return p[15:0];
    endfunction

    // Packed expectation: {dout, oe_lo, oe_hi, standby}
    function automatic logic [32:0] exp_word(input int a);
        return {ref_word(a), 8'hFF, 8'hFF, 1'b0};
    endfunction
    function automatic logic [32:0] exp_byte(input int a, input logic hi);
        logic [15:0] w;
        w = ref_word(a);
        return {8'h00, (hi ? w[15:8] : w[7:0]), 8'hFF, 8'h00, 1'b0};
    endfunction
    localparam logic [32:0] EXP_STBY  = {16'h0, 8'h0, 8'h0, 1'b1};
    localparam logic [32:0] EXP_MUTED = {16'h0, 8'h0, 8'h0, 1'b0};

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic c, input logic o, input logic o2,
                         input logic wm, input logic lb, input int a);
        @(negedge clk);
        ce_n = c; oe_n = o; oe2 = o2; word_mode = wm; lsb_in = lb; addr = AW'(a);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset state", {d_h, ol_h, oh_h, sb_h}, EXP_STBY);
        rst_n = 1'b1;

        // R1 + R7: full word sweep with lsb_in scrambled
        for (int a = 0; a < (1 << AW); a++) begin
            apply(1'b0, 1'b0, 1'b1, 1'b1, a[0] ^ a[3], a);
            check("R1 R7 word read", {d_h, ol_h, oh_h, sb_h}, exp_word(a));
        end

        // R2 / R3: full byte sweep
        for (int a = 0; a < (1 << AW); a++) begin
            for (int b = 0; b < 2; b++) begin
                apply(1'b0, 1'b0, 1'b1, 1'b0, b[0], a);
                check(b ? "R3 byte upper" : "R2 byte lower",
                      {d_h, ol_h, oh_h, sb_h}, exp_byte(a, b[0]));
            end
        end

        // R7: lsb toggled at fixed word address
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 77);
        check("R7 lsb low", {d_h, ol_h, oh_h, sb_h}, exp_word(77));
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 77);
        check("R7 lsb high", {d_h, ol_h, oh_h, sb_h}, exp_word(77));

        // R4: standby dominates
        for (int k = 0; k < 4; k++) begin
            apply(1'b1, k[0], k[1], k[0] ^ k[1], k[1], 13 * k + 5);
            check("R4 R8 standby", {d_h, ol_h, oh_h, sb_h}, EXP_STBY);
        end
        // R5: main enable off
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 200);
        check("R5 R8 muted word", {d_h, ol_h, oh_h, sb_h}, EXP_MUTED);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 201);
        check("R5 muted byte", {d_h, ol_h, oh_h, sb_h}, EXP_MUTED);

        // R6: second enable per polarity build
        apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 42);
        check("R6 act-high oe2=0", {d_h, ol_h, oh_h, sb_h}, EXP_MUTED);
        check("R6 act-low oe2=0", {d_l, ol_l, oh_l, sb_l}, exp_word(42));
        check("R6 ignore oe2=0", {d_i, ol_i, oh_i, sb_i}, exp_word(42));
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 43);
        check("R6 act-high oe2=1", {d_h, ol_h, oh_h, sb_h}, exp_byte(43, 1'b1));
        check("R6 act-low oe2=1", {d_l, ol_l, oh_l, sb_l}, EXP_MUTED);
        check("R6 ignore oe2=1", {d_i, ol_i, oh_i, sb_i}, exp_byte(43, 1'b1));

        // Same-cycle view switch and byte-select change
        for (int a = 0; a < 6; a++) begin
            apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 31 * a);
            check("R1 pre-switch", {d_h, ol_h, oh_h, sb_h}, exp_word(31 * a));
            apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 31 * a + 1);
            check("R3 switch to byte", {d_h, ol_h, oh_h, sb_h}, exp_byte(31 * a + 1, 1'b1));
            apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 31 * a + 2);
            check("R7 switch to word", {d_h, ol_h, oh_h, sb_h}, exp_word(31 * a + 2));
        end
        // Enable drop coinciding with view flip
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 9);
        check("R5 mute wins over flip", {d_h, ol_h, oh_h, sb_h}, EXP_MUTED);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10);
        check("R4 standby wins over flip", {d_h, ol_h, oh_h, sb_h}, EXP_STBY);

        // R9: reset mid-operation
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 99);
        rst_n = 1'b0;
        #1;
        check("R9 async reset", {d_h, ol_h, oh_h, sb_h}, EXP_STBY);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #1000000;
        join_any
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule